// File: doc/BRIEF.md
# Sign-Alternating Bitstream Accumulator

This block totals the one-bit comparator decisions of a single mixer channel (in-phase or quadrature) of a delta-sigma downconverter. Every clock it takes a pair of bits. The first bit of each pair was taken while the mixer was in its positive phase, and the second while it was in its negative phase. Two consecutive pairs form a four-bit group ordered positive, negative, positive, negative. Inverting the negative-phase positions (the group XORed with 0101, which is the same as inverting the second bit of every pair) lets every bit add to one unsigned ones-count.

The running count is held as two counters. A weight-2 counter advances when both bits of a pair count. A weight-1 counter advances when exactly one bit counts. The reported total is twice the first plus the second. A sample strobe, issued at four times the output sample rate, captures both counters and the combined total, and starts a new interval in the same cycle. The block also provides the negated total as a signed value for the downstream decimation filter.

Top module: `sign_alt_accum`

## Requirements
- R1: While rst_ni is low, and after reset until the first strobe, valid_o, hi_cnt_o, lo_cnt_o, count_o and value_o are all zero.
- R2: For each pair, pair_i[1] (positive phase) counts when it is 1, and pair_i[0] (negative phase) counts when it is 0. So 2'b10 counts two, 2'b01 counts zero, and 2'b11 and 2'b00 count one each.
- R3: A pair that counts two adds one to the weight-2 count. A pair that counts one adds one to the weight-1 count. A pair that counts zero changes neither count.
- R4: In the cycle after strobe_i is high, valid_o is high, and hi_cnt_o and lo_cnt_o give the counts of the pairs from the previous strobe cycle (or from reset) up to the cycle before this strobe.
- R5: The pair present in a strobe cycle is counted into the new interval and is not lost.
- R6: count_o equals 2*hi_cnt_o + lo_cnt_o, and value_o equals the negation of count_o as a signed number one bit wider.
- R7: valid_o is high only in the cycle after a strobe. The captured outputs hold their values until the next strobe.
- R8: For strobe spacings up to MAX_INTERVAL cycles, no count wraps. With all pairs counting two, a full interval reports 2*MAX_INTERVAL.
- R9: Strobes on consecutive cycles each report a one-cycle interval made up of the single pair of the preceding strobe cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pair_i | input | 2 | Bit pair: [1] positive phase, [0] negative phase |
| strobe_i | input | 1 | Capture totals and start a new interval |
| valid_o | output | 1 | Captured totals updated this cycle |
| hi_cnt_o | output | CNT_W | Captured weight-2 count |
| lo_cnt_o | output | CNT_W | Captured weight-1 count |
| count_o | output | SUM_W | Captured unsigned total 2*hi+lo |
| value_o | output | SUM_W+1 | Negated total, signed |

## Verification
The in-line properties check on every cycle that a pair never advances both counters at once, that a counter never wraps within an interval, that a strobe leaves at most one count in the fresh interval, that valid_o follows the strobe exactly one cycle later, that captured outputs hold between strobes, and that the signed output mirrors the unsigned total. Only the bench scenarios can show that the totals are numerically right: the mapping of each bit pattern to its weight, pairs that land on a strobe cycle, back-to-back strobes, and a full-length interval at the overflow limit. These are compared against a reference model.

// File: rtl/sa_accum_pkg.sv
package sa_accum_pkg;
  // Per-pair inversion mask; a nibble mask of 4'b0101 is two of these.
  localparam logic [1:0] NEG_MASK = 2'b01;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sa_pair_adjust.sv
module sa_pair_adjust
  import sa_accum_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] pair_i,
  output logic       inc_hi_o,
  output logic       inc_lo_o
);
  logic [1:0] adj;

  always_comb begin
    adj      = pair_i ^ NEG_MASK;
    inc_hi_o = &adj;
    inc_lo_o = ^adj;
  end

  // R3: a pair feeds exactly one weight.
  a_r3_one_weight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_hi_o && inc_lo_o));
  // R2: the all-negative pattern counts nothing.
  a_r2_zero_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_i == 2'b01) |-> (!inc_hi_o && !inc_lo_o));
endmodule

// File: rtl/sa_split_counter.sv
module sa_split_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  // On a strobe the current pair seeds the new interval.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= W'(inc_i);
    else            cnt_q <= cnt_q + W'(inc_i);
  end

  assign cnt_o = cnt_q;

  // R5: a fresh interval holds at most the strobe-cycle pair.
  a_r5_fresh_interval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q <= W'(1)));
  // R8: within an interval the counter never wraps to zero.
  a_r8_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i) |=> (cnt_q != '0));
endmodule

// File: rtl/sa_sample_stage.sv
module sa_sample_stage #(
  parameter int CNT_W = 13,
  parameter int SUM_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    strobe_i,
  input  logic [CNT_W-1:0]        hi_i,
  input  logic [CNT_W-1:0]        lo_i,
  output logic                    valid_o,
  output logic [CNT_W-1:0]        hi_o,
  output logic [CNT_W-1:0]        lo_o,
  output logic [SUM_W-1:0]        count_o,
  output logic signed [SUM_W:0]   value_o
);
  logic [SUM_W-1:0] total;

  always_comb total = (SUM_W'(hi_i) << 1) + SUM_W'(lo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      hi_o    <= '0;
      lo_o    <= '0;
      count_o <= '0;
      value_o <= '0;
    end else begin
      valid_o <= strobe_i;
      if (strobe_i) begin
        hi_o    <= hi_i;
        lo_o    <= lo_i;
        count_o <= total;
        value_o <= -$signed({1'b0, total});
      end
    end
  end

  // R7: valid follows the strobe by exactly one cycle.
  a_r7_valid_timing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> valid_o);
  a_r7_valid_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> !valid_o);
  // R7: captured values hold between strobes.
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(count_o) && $stable(hi_o) && $stable(lo_o)));
  // R6: signed output mirrors the unsigned total.
  a_r6_negation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (value_o + $signed({1'b0, count_o})) == '0);
endmodule

// File: rtl/sign_alt_accum.sv
module sign_alt_accum
  import sa_accum_pkg::*;
#(
  parameter  int MAX_INTERVAL = 4096,
  localparam int CNT_W = $clog2(MAX_INTERVAL + 1),
  localparam int SUM_W = int'(max_u(16, $clog2(2 * MAX_INTERVAL + 1)))
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            pair_i,
  input  logic                  strobe_i,
  output logic                  valid_o,
  output logic [CNT_W-1:0]      hi_cnt_o,
  output logic [CNT_W-1:0]      lo_cnt_o,
  output logic [SUM_W-1:0]      count_o,
  output logic signed [SUM_W:0] value_o
);
  localparam int NUM_CNT = 2; // index 1: weight-2, index 0: weight-1

  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt [NUM_CNT];

  sa_pair_adjust u_adj (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pair_i   (pair_i),
    .inc_hi_o (inc[1]),
    .inc_lo_o (inc[0])
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    sa_split_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (strobe_i),
      .inc_i  (inc[g]),
      .cnt_o  (cnt[g])
    );
  end

  sa_sample_stage #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_smp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .hi_i     (cnt[1]),
    .lo_i     (cnt[0]),
    .valid_o  (valid_o),
    .hi_o     (hi_cnt_o),
    .lo_o     (lo_cnt_o),
    .count_o  (count_o),
    .value_o  (value_o)
  );
endmodule

// File: tb/sim_sign_alt_accum.sv
module sim_sign_alt_accum;
  localparam int MAXI  = 4096;
  localparam int CNT_W = $clog2(MAXI + 1);
  localparam int SUM_W = ($clog2(2 * MAXI + 1) > 16) ? $clog2(2 * MAXI + 1) : 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pair = 2'b01;
  logic strobe = 1'b0;
  logic valid;
  logic [CNT_W-1:0] hi_cnt, lo_cnt;
  logic [SUM_W-1:0] count;
  logic signed [SUM_W:0] value;

  always #2ns clk = ~clk;

  sign_alt_accum #(.MAX_INTERVAL(MAXI)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pair_i(pair), .strobe_i(strobe),
    .valid_o(valid), .hi_cnt_o(hi_cnt), .lo_cnt_o(lo_cnt),
    .count_o(count), .value_o(value)
  );

  int checks = 0;
  int errors = 0;

  typedef struct { int hi; int lo; string tag; } exp_t;
  exp_t exp_q[$];
  int m_hi = 0, m_lo = 0;
  int last_count = 0;
  string cur_tag = "R4";

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R2/R3 reference: positive bit counts on 1, negative bit on 0.
  task automatic drive(input logic [1:0] p, input logic s);
    int c;
    @(negedge clk);
    pair = p;
    strobe = s;
    c = int'(p[1]) + int'(!p[0]);
    if (s) begin
      exp_q.push_back('{m_hi, m_lo, cur_tag});
      m_hi = (c == 2) ? 1 : 0;
      m_lo = (c == 1) ? 1 : 0;
    end else begin
      if (c == 2) m_hi++;
      if (c == 1) m_lo++;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " hi"}, int'(hi_cnt), e.hi);
        check({e.tag, " lo"}, int'(lo_cnt), e.lo);
        check({e.tag, " R6 count"}, int'(count), 2 * e.hi + e.lo);
        check({e.tag, " R6 value"}, int'(value), -(2 * e.hi + e.lo));
        last_count = 2 * e.hi + e.lo;
      end
    end
  end

  initial begin
    #1ms;
    check("watchdog", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", int'(valid), 0);
    check("R1 count", int'(count), 0);
    check("R1 value", int'(value), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post valid", int'(valid), 0);
    check("R1 post hi", int'(hi_cnt), 0);

    // R2/R3: each pattern alone
    cur_tag = "R2";
    drive(2'b01, 1'b1);   // first interval since reset: empty
    drive(2'b10, 1'b0); drive(2'b10, 1'b0);
    drive(2'b01, 1'b1);
    drive(2'b11, 1'b0); drive(2'b00, 1'b0); drive(2'b11, 1'b0);
    cur_tag = "R3";
    drive(2'b01, 1'b1);
    // R3: mixed nibbles
    drive(2'b10, 1'b0); drive(2'b11, 1'b0); drive(2'b01, 1'b0);
    drive(2'b00, 1'b0); drive(2'b10, 1'b0); drive(2'b10, 1'b0);
    cur_tag = "R5";
    // R5: strobe-cycle pair counts into the new interval
    drive(2'b10, 1'b1);
    drive(2'b00, 1'b0);
    cur_tag = "R9";
    drive(2'b11, 1'b1);
    // R9: back-to-back strobes
    drive(2'b10, 1'b1);
    drive(2'b01, 1'b1);
    cur_tag = "R4";
    drive(2'b00, 1'b1);
    for (int i = 0; i < 37; i++) drive(i[0] ? 2'b10 : 2'b11, 1'b0);
    drive(2'b01, 1'b1);
    // R7: hold while counting
    drive(2'b10, 1'b0);
    for (int i = 0; i < 5; i++) drive(2'b10, 1'b0);
    check("R7 hold", int'(count), last_count);
    check("R7 valid low", int'(valid), 0);
    cur_tag = "R8";
    // R8: full interval, all pairs counting two
    drive(2'b10, 1'b1);
    for (int i = 0; i < MAXI - 1; i++) drive(2'b10, 1'b0);
    drive(2'b01, 1'b1);
    drive(2'b01, 1'b0);
    drive(2'b01, 1'b0);
    check("R8 full", int'(count), 2 * MAXI);
    check("R4 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule